// File: doc/BRIEF.md
# Flash Protected-Range Access Checker

This block sits in front of a serial flash sequencer and judges every access request before any bus cycle is started. It holds five protected-range registers and one lower-bound base register. Each range register holds two things. The first is a pair of enables, one for write/erase and one for read. The second is an inclusive window of 4 KB pages, given as 13-bit page numbers on the 25-bit flash address. A request brings an address and a write/erase-or-read flag, and the block answers in the same cycle with either a grant or a deny.

The range registers can be changed freely until the lockdown input is seen high. From that point they are frozen until reset, and their windows are enforced. The base register drops every bit outside 23:8, and any access to an address below it is refused whether or not the block is locked. Every refusal sets a sticky violation flag. Software clears that flag by writing a one through the same configuration port.

Top module: `flash_guard`

## Requirements
- R1: After reset, all five range registers, the base register, the violation flag and the lock state read as zero, and every request is granted.
- R2: Configuration select 0 to 4 addresses the range registers, select 5 the base register and select 6 the status word (bit 0 is the violation flag). A range register stores bit 31 (write/erase protect), bits 28:16 (upper page), bit 15 (read protect) and bits 12:0 (lower page). Bits 30:29 and 14:13 always read as zero. The readback is combinational on the select.
- R3: One cycle of the lockdown input high locks the block until reset. Once locked, writes to the range registers are ignored.
- R4: Range registers have no effect on requests while the block is unlocked.
- R5: When locked, a write/erase request is denied if a range with bit 31 set has lower*4096 <= address <= upper*4096+4095. Both ends are inclusive.
- R6: Read protection (bit 15) denies only reads and write protection (bit 31) denies only write/erase requests.
- R7: A range whose lower page is greater than its upper page matches no address.
- R8: The base register keeps only bits 23:8. Any request whose address is below the kept value is denied, in both the locked and unlocked state. The base register stays writable after lock.
- R9: While a request is valid, exactly one of grant and deny is high in the same cycle. With no request, both are low.
- R10: A denied request sets the violation flag on the next clock edge. The flag holds until a write to select 6 with bit 0 set clears it. A deny in the same cycle as the clear wins.
- R11: Each of the five range registers, including index 0 and index 4, can deny a request on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational readback of the selected register |
| lock_in | input | 1 | Lockdown request, sticky once seen |
| req_valid | input | 1 | Access request valid |
| req_addr | input | 25 | Flash byte address of the request |
| req_write | input | 1 | 1 = write/erase, 0 = read |
| grant | output | 1 | Request allowed |
| deny | output | 1 | Request refused |
| viol_flag | output | 1 | Sticky violation flag |

## Verification
Requests are sent at the first and last byte of each protected window and one byte outside it on each side. This separates inclusive bounds from off-by-one windows and whole-page masking from byte masking. The same addresses are sent as reads and as writes, which shows whether the two enables are kept apart. The same window is also tried before and after lock, which shows whether enforcement is tied to the lock. An inverted window and addresses on either side of the base bound check the empty-match rule and the masked base compare. Range writes after lock, and a deny that lands in the same cycle as a flag clear, check the freeze and the set-over-clear priority.

// File: rtl/fg_pkg.sv
// Package: field positions and register selects shared by the range checker.
// Assumes 32-bit range words with 4 KB pages on a 25-bit flash address.
package fg_pkg;
    localparam int WORD_W   = 32;
    localparam int PAGE_W   = 13;
    localparam int PAGE_SH  = 12;
    localparam int WP_BIT   = 31;
    localparam int RP_BIT   = 15;
    localparam int HI_LSB   = 16;
    localparam int LO_LSB   = 0;
    localparam logic [WORD_W-1:0] RANGE_KEEP = 32'h9FFF_9FFF;
    localparam logic [WORD_W-1:0] BASE_KEEP  = 32'h00FF_FF00;

    typedef struct packed {
        logic              wp;
        logic              rp;
        logic [PAGE_W-1:0] hi;
        logic [PAGE_W-1:0] lo;
    } range_t;

    // Unpack a stored range word into its fields.
    function automatic range_t unpack_range(input logic [WORD_W-1:0] w);
        range_t r;
        r.wp = w[WP_BIT];
        r.rp = w[RP_BIT];
        r.hi = w[HI_LSB +: PAGE_W];
        r.lo = w[LO_LSB +: PAGE_W];
        return r;
    endfunction
endpackage

// File: rtl/fg_regs.sv
// Module: fg_regs
// Holds the protected-range registers, the base register and the lock state.
// Assumes select values 0..NUM_RANGES-1 address ranges and NUM_RANGES the base.
module fg_regs #(
    parameter int NUM_RANGES = 5,
    parameter int SEL_W      = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [SEL_W-1:0]                    cfg_sel,
    input  logic [fg_pkg::WORD_W-1:0]           cfg_wdata,
    input  logic                                lock_in,
    output logic [NUM_RANGES-1:0][fg_pkg::WORD_W-1:0] rng_q,
    output logic [fg_pkg::WORD_W-1:0]           base_q,
    output logic                                locked_q
);
    localparam int BASE_SEL = NUM_RANGES;

    // Sticky lock: set by the lockdown input, released only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked_q <= 1'b0;
        else if (lock_in) locked_q <= 1'b1;
    end

    // Base bound register: always writable, low and high bits discarded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (cfg_we && (cfg_sel == SEL_W'(BASE_SEL)))
            base_q <= cfg_wdata & fg_pkg::BASE_KEEP;
    end

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_rng
        // Range register i: writable only until lock, reserved bits dropped.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rng_q[i] <= '0;
            else if (cfg_we && !locked_q && (cfg_sel == SEL_W'(i)))
                rng_q[i] <= cfg_wdata & fg_pkg::RANGE_KEEP;
        end
    end
endmodule

// File: rtl/fg_match.sv
// Module: fg_match
// Decides whether one range covers the requested page for the request type.
// Assumes an inverted window (lower above upper) covers nothing.
module fg_match (
    input  fg_pkg::range_t              rng,
    input  logic [fg_pkg::PAGE_W-1:0]   page,
    input  logic                        is_write,
    output logic                        hit
);
    logic in_window;
    logic enabled;

    // Inclusive page window test and per-type enable select.
    always_comb begin
        in_window = (page >= rng.lo) && (page <= rng.hi);
        enabled   = is_write ? rng.wp : rng.rp;
        hit       = in_window && enabled;
    end
endmodule

// File: rtl/fg_decide.sv
// Module: fg_decide
// Combines range hits and the base bound into grant/deny and keeps the
// sticky violation flag. Assumes hits are already qualified by the lock.
module fg_decide #(
    parameter int NUM_RANGES = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [NUM_RANGES-1:0] range_hits,
    input  logic                  below_base,
    input  logic                  flag_clr,
    output logic                  grant,
    output logic                  deny,
    output logic                  viol_flag
);
    logic blocked;

    // Same-cycle decision for the presented request.
    always_comb begin
        blocked = below_base || (|range_hits);
        deny    = req_valid && blocked;
        grant   = req_valid && !blocked;
    end

    // Sticky violation flag: a new deny takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        viol_flag <= 1'b0;
        else if (deny)     viol_flag <= 1'b1;
        else if (flag_clr) viol_flag <= 1'b0;
    end
endmodule

// File: rtl/flash_guard.sv
// Module: flash_guard (top)
// Flash protected-range access checker: five range registers, a base bound,
// lockdown and a sticky violation flag. Assumes one request per cycle and a
// single configuration port with combinational readback.
module flash_guard #(
    parameter int NUM_RANGES = 5,
    parameter int ADDR_W     = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        lock_in,
    input  logic        req_valid,
    input  logic [24:0] req_addr,
    input  logic        req_write,
    output logic        grant,
    output logic        deny,
    output logic        viol_flag
);
    localparam int SEL_W    = 3;
    localparam int WORD_W   = fg_pkg::WORD_W;
    localparam int BASE_SEL = NUM_RANGES;
    localparam int STAT_SEL = NUM_RANGES + 1;

    logic [NUM_RANGES-1:0][WORD_W-1:0] rng_q;
    logic [WORD_W-1:0]                 base_q;
    logic                              locked_q;
    logic [NUM_RANGES-1:0]             raw_hits;
    logic [NUM_RANGES-1:0]             range_hits;
    logic                              below_base;
    logic                              flag_clr;
    logic [fg_pkg::PAGE_W-1:0]         req_page;

    fg_regs #(.NUM_RANGES(NUM_RANGES), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .lock_in   (lock_in),
        .rng_q     (rng_q),
        .base_q    (base_q),
        .locked_q  (locked_q)
    );

    assign req_page = req_addr[ADDR_W-1 -: fg_pkg::PAGE_W];

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_match
        fg_match u_match (
            .rng      (fg_pkg::unpack_range(rng_q[i])),
            .page     (req_page),
            .is_write (req_write),
            .hit      (raw_hits[i])
        );
    end

    // Range windows apply only once the block is locked.
    always_comb range_hits = locked_q ? raw_hits : '0;

    // Base bound compare on the zero-extended byte address.
    always_comb below_base = ({{(WORD_W-ADDR_W){1'b0}}, req_addr} < base_q);

    // Flag clear strobe: write to the status select with bit 0 set.
    always_comb flag_clr = cfg_we && (cfg_sel == SEL_W'(STAT_SEL)) && cfg_wdata[0];

    fg_decide #(.NUM_RANGES(NUM_RANGES)) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .range_hits (range_hits),
        .below_base (below_base),
        .flag_clr   (flag_clr),
        .grant      (grant),
        .deny       (deny),
        .viol_flag  (viol_flag)
    );

    // Readback multiplexer over ranges, base and status.
    always_comb begin
        cfg_rdata = '0;
        if (int'(cfg_sel) < NUM_RANGES)
            cfg_rdata = rng_q[cfg_sel];
        else if (int'(cfg_sel) == BASE_SEL)
            cfg_rdata = base_q;
        else if (int'(cfg_sel) == STAT_SEL)
            cfg_rdata = {{(WORD_W-1){1'b0}}, viol_flag};
    end
endmodule

// File: rtl/flash_guard_chk.sv
// Module: flash_guard_chk
// Assertion checker bound to flash_guard; watches the decision outputs,
// the lock state and the stored range words.
module flash_guard_chk #(
    parameter int NUM_RANGES = 5
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      req_valid,
    input logic                                      grant,
    input logic                                      deny,
    input logic                                      viol_flag,
    input logic                                      locked_q,
    input logic [NUM_RANGES-1:0][fg_pkg::WORD_W-1:0] rng_q
);
    // R9
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (grant ^ deny));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!grant && !deny));

    // R10
    flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deny |=> viol_flag);

    // R3
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> ($stable(rng_q) && locked_q));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!viol_flag && !locked_q && (rng_q == '0)));
endmodule

bind flash_guard flash_guard_chk #(.NUM_RANGES(NUM_RANGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .grant     (grant),
    .deny      (deny),
    .viol_flag (viol_flag),
    .locked_q  (locked_q),
    .rng_q     (rng_q)
);

// File: tb/flash_guard_tb.sv
// Scoreboard bench for flash_guard: a driver pushes expected grant/deny
// pairs computed from a requirement model; a monitor pops and compares.
module flash_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lock_in = 1'b0;
    logic        req_valid = 1'b0;
    logic [24:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        grant, deny, viol_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    logic [31:0] m_rng [5];
    logic [31:0] m_base;
    logic        m_locked;

    always #4 clk = ~clk;

    flash_guard u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lock_in(lock_in),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .grant(grant), .deny(deny), .viol_flag(viol_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model_deny(input logic [24:0] a, input logic w);
        logic d;
        d = ({7'b0, a} < m_base);
        if (m_locked)
            for (int i = 0; i < 5; i++) begin
                logic [12:0] lo, hi, pg;
                lo = m_rng[i][12:0];
                hi = m_rng[i][28:16];
                pg = a[24:12];
                if ((w ? m_rng[i][31] : m_rng[i][15]) && pg >= lo && pg <= hi) d = 1'b1;
            end
        return d;
    endfunction

    task automatic wr_cfg(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        if (sel < 3'd5 && !m_locked) m_rng[sel] = data & 32'h9FFF_9FFF;
        if (sel == 3'd5) m_base = data & 32'h00FF_FF00;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_sel = sel;
        #1 check(req, cfg_rdata, exp);
    endtask

    task automatic do_req(input logic [24:0] a, input logic w, input string tag);
        logic d;
        d = model_deny(a, w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        exp_q.push_back({~d, d});
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare outputs against the queued expectation, off the edge.
    initial forever begin
        @(negedge clk);
        #1;
        if (req_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9: unexpected request actual=1 expected=0");
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {30'b0, grant, deny}, {30'b0, e});
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 5; i++) m_rng[i] = '0;
        m_base = '0; m_locked = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of all selects
        for (int s = 0; s < 7; s++) rd_chk(3'(s), 32'h0, "R1 reset readback");
        do_req(25'h1FF_FFFF, 1'b1, "R1 grant after reset");
        // R9 idle: no grant and no deny
        @(negedge clk); #1 check("R9 idle outputs", {30'b0, grant, deny}, 32'h0);

        // R2 reserved bits dropped
        wr_cfg(3'd1, 32'hFFFF_FFFF);
        rd_chk(3'd1, 32'h9FFF_9FFF, "R2 reserved bits zero");
        wr_cfg(3'd1, 32'h0);
        // program windows
        wr_cfg(3'd0, 32'h801F_0010);   // write-protect pages 0x010..0x01F
        wr_cfg(3'd4, 32'h0100_8100);   // read-protect page 0x100
        wr_cfg(3'd2, 32'h8040_8050);   // inverted window
        rd_chk(3'd0, 32'h801F_0010, "R2 range0 readback");
        rd_chk(3'd4, 32'h0100_8100, "R2 range4 readback");

        // R4 unlocked: windows ignored
        do_req(25'h001_0000, 1'b1, "R4 unlocked write");
        do_req(25'h010_0000, 1'b0, "R4 unlocked read");

        // R3 lock then attempt overwrite
        @(negedge clk); lock_in = 1'b1; m_locked = 1'b1;
        @(negedge clk); lock_in = 1'b0;
        wr_cfg(3'd0, 32'h0);
        rd_chk(3'd0, 32'h801F_0010, "R3 write ignored after lock");

        // R5 inclusive edges, R11 index 0
        do_req(25'h001_0000, 1'b1, "R5 R11 lower edge write");
        do_req(25'h001_FFFF, 1'b1, "R5 upper edge write");
        do_req(25'h000_FFFF, 1'b1, "R5 below window write");
        do_req(25'h002_0000, 1'b1, "R5 above window write");
        // R6 type separation, R11 index 4
        do_req(25'h001_0000, 1'b0, "R6 read in write window");
        do_req(25'h010_0000, 1'b0, "R6 R11 read window low");
        do_req(25'h010_0FFF, 1'b0, "R6 read window high");
        do_req(25'h010_1000, 1'b0, "R6 read past window");
        do_req(25'h010_0000, 1'b1, "R6 write in read window");
        // R7 inverted window
        do_req(25'h004_5000, 1'b1, "R7 inverted write");
        do_req(25'h005_0000, 1'b0, "R7 inverted read");

        // R10 flag behaviour
        rd_chk(3'd6, 32'h1, "R10 flag set after deny");
        wr_cfg(3'd6, 32'h1);
        rd_chk(3'd6, 32'h0, "R10 flag cleared");
        do_req(25'h002_0000, 1'b1, "R10 granted request");
        rd_chk(3'd6, 32'h0, "R10 grant leaves flag");
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd6; cfg_wdata = 32'h1;
        req_valid = 1'b1; req_addr = 25'h001_0000; req_write = 1'b1;
        exp_q.push_back(2'b01); tag_q.push_back("R10 deny with clear");
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        rd_chk(3'd6, 32'h1, "R10 deny wins over clear");
        wr_cfg(3'd6, 32'h1);

        // R8 base bound
        wr_cfg(3'd5, 32'hFFFF_FFFF);
        rd_chk(3'd5, 32'h00FF_FF00, "R8 base masked");
        do_req(25'h0FF_FEFF, 1'b0, "R8 below base read");
        do_req(25'h0FF_FF00, 1'b0, "R8 at base read");
        do_req(25'h100_0000, 1'b1, "R8 above base write");
        wr_cfg(3'd5, 32'h0020_0000);
        do_req(25'h01F_FFFF, 1'b1, "R8 below base write");
        do_req(25'h020_0000, 1'b1, "R8 at base write");

        repeat (3) @(negedge clk);
        check("R9 scoreboard drained", exp_q.size(), 32'h0);
        finish_run();
    end
endmodule